// File: doc/BRIEF.md
# Chained Receive Descriptor DMA

This block moves received Ethernet frames from a byte stream into memory buffers. Each buffer is described by a 16-byte descriptor in memory, made of four 32-bit words: a status word, a control word, a buffer address and a next-descriptor pointer. The engine reads a descriptor through a simple word-wide memory master port and checks that it owns it. It then packs the incoming frame bytes into little-endian words and writes them into the buffer. At the end of the frame it writes only the status word back, handing the descriptor to the host.

After a frame, the engine moves to the next descriptor. That is the base address when the control word marks the end of the ring, or the pointer in word 3 when the control word marks a chained descriptor; with neither mark it takes the descriptor that follows in memory. When the engine meets a descriptor the host has not released, it suspends. A poll-demand pulse makes it read that descriptor again. Frames that arrive while it is suspended are accepted, dropped and counted.

The memory port holds a request, with its address, direction and data, until the memory answers with a one-cycle acknowledge. The frame input is a valid/ready byte stream whose last byte carries the end-of-frame and error flags.

Top module: `rx_desc_dma`

## Requirements
- R1: When `rxEnable` is raised, the engine reads the status word at `descBase`. It reads the control word, buffer address and pointer words at offsets +4, +8 and +12 only when status bit 31 (ownership) is 1. A memory request holds its address and direction stable until `memAck`.
- R2: Byte k of a frame is written into byte lane k mod 4 (lane 0 = bits 7:0) of the word at buffer address + 4*(k div 4). Unfilled lanes of a frame's final word are written as zero.
- R3: At the end of a frame, the status word is written at the descriptor address with bit 31 = 0, bit 30 = 1, bit 8 = 1, and bits 29:16 = the number of bytes in the frame, including the 4 check-sequence bytes.
- R4: If any byte of the frame arrives with `frmErr` high, status bit 15 (error summary) is written as 1; otherwise it is 0.
- R5: Bytes at positions at or beyond the buffer size (control bits 10:0) are not written to memory. For such a frame, bit 15 is set and bits 29:16 still give the full length.
- R6: After the write-back, the next descriptor is `descBase` when control bit 25 is set. Otherwise it is the address held in word 3 when control bit 24 is set.
- R7: A descriptor read with bit 31 = 0 causes suspension: no memory access until a `pollDemand` pulse, which re-reads the same status word.
- R8: A frame arriving while the engine is suspended is accepted, written nowhere, and increments `missCount` by one.
- R9: The control word of a descriptor is never written by the engine.
- R10: A `pollDemand` pulse in the same cycle as the last byte of a discarded frame both counts the missed frame and starts the descriptor re-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Starts the engine at `descBase` when raised from the idle state |
| pollDemand | input | 1 | One-cycle request to re-read the current descriptor |
| descBase | input | ADDR_W | Address of the first descriptor of the ring |
| frmValid | input | 1 | A frame byte is present |
| frmData | input | 8 | Frame byte |
| frmLast | input | 1 | This byte ends the frame |
| frmErr | input | 1 | This byte is flagged bad by the receiver |
| frmReady | output | 1 | The engine accepts the byte this cycle |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Access complete |
| missCount | output | MISS_W | Number of frames dropped while suspended |

## Verification
Two functions can fall in one clock edge: the miss counter stepping at the last byte of a frame dropped during suspension, and a poll demand restarting the descriptor fetch. The bench drives the poll pulse on exactly the cycle that carries the final byte of a dropped frame. It then judges that the counter rose by exactly one and that the released descriptor is read and filled by the next frame. Every memory write is compared, as it is acknowledged, against a queue of writes predicted from the descriptors and frame contents.

// File: rtl/rx_desc_dma_pkg.sv
package rx_desc_dma_pkg;

  localparam int WORD_W       = 32;
  localparam int DESC_BYTES   = 16;
  localparam int OWN_BIT      = 31;
  localparam int FIRST_BIT    = 30;
  localparam int LEN_LSB      = 16;
  localparam int ERR_BIT      = 15;
  localparam int LAST_BIT     = 8;
  localparam int RING_END_BIT = 25;
  localparam int CHAIN_BIT    = 24;

  typedef enum logic [2:0] {
    OP_NONE, OP_RD_STS, OP_RD_CTL, OP_RD_BUF, OP_RD_NXT, OP_WR_DATA, OP_WR_STS
  } memOp_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH_STS, ST_FETCH_CTL, ST_FETCH_BUF, ST_FETCH_NXT,
    ST_READY, ST_WDATA, ST_WSTAT, ST_SUSPEND
  } engState_t;

  typedef struct packed {
    logic   loadBase;
    logic   advance;
    logic   clrFrame;
    logic   take;
    logic   countMiss;
    memOp_t memOp;
  } dpStrobe_t;

endpackage

// File: rtl/rx_desc_dma_ctrl.sv
module rx_desc_dma_ctrl
  import rx_desc_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      pollDemand,
  input  logic      frmValid,
  input  logic      frmLast,
  input  logic      memAck,
  input  logic      ownBit,
  input  logic      needWrite,
  input  logic      lastPend,
  output logic      frmReady,
  output dpStrobe_t strb
);

  engState_t state, nextState;
  logic inFrame, inFrameNext, pollPending, pollSeen;

  assign frmReady    = (state == ST_IDLE) || (state == ST_READY) || (state == ST_SUSPEND);
  assign inFrameNext = (frmValid && frmReady) ? !frmLast : inFrame;
  assign pollSeen    = pollPending || pollDemand;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (rxEnable && !inFrameNext) begin
          strb.loadBase = 1'b1;
          nextState     = ST_FETCH_STS;
        end
      end
      ST_FETCH_STS: begin
        strb.memOp = OP_RD_STS;
        if (memAck) nextState = ownBit ? ST_FETCH_CTL : ST_SUSPEND;
      end
      ST_FETCH_CTL: begin
        strb.memOp = OP_RD_CTL;
        if (memAck) nextState = ST_FETCH_BUF;
      end
      ST_FETCH_BUF: begin
        strb.memOp = OP_RD_BUF;
        if (memAck) nextState = ST_FETCH_NXT;
      end
      ST_FETCH_NXT: begin
        strb.memOp = OP_RD_NXT;
        if (memAck) nextState = ST_READY;
      end
      ST_READY: begin
        if (frmValid) begin
          strb.take = 1'b1;
          if (needWrite)    nextState = ST_WDATA;
          else if (frmLast) nextState = ST_WSTAT;
        end
      end
      ST_WDATA: begin
        strb.memOp = OP_WR_DATA;
        if (memAck) nextState = lastPend ? ST_WSTAT : ST_READY;
      end
      ST_WSTAT: begin
        strb.memOp = OP_WR_STS;
        if (memAck) begin
          strb.advance  = 1'b1;
          strb.clrFrame = 1'b1;
          nextState     = ST_FETCH_STS;
        end
      end
      ST_SUSPEND: begin
        strb.countMiss = frmValid && frmLast;
        if (!inFrameNext) begin
          if (!rxEnable)     nextState = ST_IDLE;
          else if (pollSeen) nextState = ST_FETCH_STS;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      inFrame     <= 1'b0;
      pollPending <= 1'b0;
    end else begin
      state       <= nextState;
      inFrame     <= inFrameNext;
      pollPending <= (nextState == ST_FETCH_STS && state != ST_FETCH_STS) ? 1'b0 : pollSeen;
    end
  end

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSPEND && !pollSeen) |=> (state == ST_SUSPEND || state == ST_IDLE)); // R7

endmodule

// File: rtl/rx_desc_dma_datapath.sv
module rx_desc_dma_datapath
  import rx_desc_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14,
  parameter int SIZE_W = 11,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] descBase,
  input  dpStrobe_t         strb,
  input  logic [7:0]        frmData,
  input  logic              frmLast,
  input  logic              frmErr,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              needWrite,
  output logic              lastPend,
  output logic [MISS_W-1:0] missCount
);

  localparam int LANE_BITS = $clog2(WORD_W / 8);

  logic [ADDR_W-1:0]    curAddr, bufAddr, nxtAddr, wordAddr, nextDesc;
  logic [SIZE_W-1:0]    bufSize;
  logic                 chainFlag, ringEnd, dirty, errSum, stored;
  logic [LEN_W-1:0]     byteCnt;
  logic [LANE_BITS-1:0] lane;
  logic [WORD_W-1:0]    asmWord, stsWord;

  assign lane      = byteCnt[LANE_BITS-1:0];
  assign stored    = byteCnt < LEN_W'(bufSize);
  assign needWrite = (stored && (&lane)) || (frmLast && (dirty || stored));
  assign nextDesc  = ringEnd   ? descBase :
                     chainFlag ? nxtAddr  : curAddr + ADDR_W'(DESC_BYTES);

  always_comb begin
    stsWord                     = '0;
    stsWord[LEN_LSB +: LEN_W]   = byteCnt;
    stsWord[FIRST_BIT]          = 1'b1;
    stsWord[LAST_BIT]           = 1'b1;
    stsWord[ERR_BIT]            = errSum;
  end

  always_comb begin
    memReq   = strb.memOp != OP_NONE;
    memWe    = (strb.memOp == OP_WR_DATA) || (strb.memOp == OP_WR_STS);
    memWdata = (strb.memOp == OP_WR_DATA) ? asmWord : stsWord;
    case (strb.memOp)
      OP_RD_CTL:  memAddr = curAddr + ADDR_W'(4);
      OP_RD_BUF:  memAddr = curAddr + ADDR_W'(8);
      OP_RD_NXT:  memAddr = curAddr + ADDR_W'(12);
      OP_WR_DATA: memAddr = wordAddr;
      default:    memAddr = curAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      bufAddr   <= '0;
      nxtAddr   <= '0;
      bufSize   <= '0;
      chainFlag <= 1'b0;
      ringEnd   <= 1'b0;
      wordAddr  <= '0;
      asmWord   <= '0;
      byteCnt   <= '0;
      dirty     <= 1'b0;
      errSum    <= 1'b0;
      lastPend  <= 1'b0;
      missCount <= '0;
    end else begin
      if (strb.loadBase) curAddr <= descBase;
      if (strb.advance)  curAddr <= nextDesc;
      if (memAck) begin
        case (strb.memOp)
          OP_RD_CTL: begin
            bufSize   <= memRdata[SIZE_W-1:0];
            chainFlag <= memRdata[CHAIN_BIT];
            ringEnd   <= memRdata[RING_END_BIT];
          end
          OP_RD_BUF:  bufAddr <= memRdata[ADDR_W-1:0];
          OP_RD_NXT:  nxtAddr <= memRdata[ADDR_W-1:0];
          OP_WR_DATA: begin
            asmWord <= '0;
            dirty   <= 1'b0;
          end
          default: ;
        endcase
      end
      if (strb.take) begin
        if (stored) begin
          asmWord[{lane, 3'b000} +: 8] <= frmData;
          dirty <= 1'b1;
          if (lane == '0)
            wordAddr <= bufAddr + ADDR_W'({byteCnt[LEN_W-1:LANE_BITS], {LANE_BITS{1'b0}}});
        end
        byteCnt  <= byteCnt + LEN_W'(1);
        errSum   <= errSum | frmErr | !stored;
        lastPend <= frmLast;
      end
      if (strb.clrFrame) begin
        byteCnt  <= '0;
        errSum   <= 1'b0;
        lastPend <= 1'b0;
        dirty    <= 1'b0;
        asmWord  <= '0;
      end
      if (strb.countMiss) missCount <= missCount + MISS_W'(1);
    end
  end

  AST_NO_CTL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr != curAddr + ADDR_W'(4))); // R9

  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memOp == OP_WR_DATA) |-> ((wordAddr - bufAddr) < ADDR_W'(bufSize))); // R5

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (missCount != $past(missCount)) |-> (missCount == $past(missCount) + MISS_W'(1))); // R8

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rx_desc_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14,
  parameter int SIZE_W = 11,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              pollDemand,
  input  logic [ADDR_W-1:0] descBase,
  input  logic              frmValid,
  input  logic [7:0]        frmData,
  input  logic              frmLast,
  input  logic              frmErr,
  output logic              frmReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck,
  output logic [MISS_W-1:0] missCount
);

  dpStrobe_t strb;
  logic needWrite, lastPend;

  rx_desc_dma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .pollDemand(pollDemand),
    .frmValid(frmValid), .frmLast(frmLast), .memAck(memAck),
    .ownBit(memRdata[OWN_BIT]), .needWrite(needWrite), .lastPend(lastPend),
    .frmReady(frmReady), .strb(strb)
  );

  rx_desc_dma_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .MISS_W(MISS_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .descBase(descBase), .strb(strb),
    .frmData(frmData), .frmLast(frmLast), .frmErr(frmErr),
    .memRdata(memRdata), .memAck(memAck),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .needWrite(needWrite), .lastPend(lastPend), .missCount(missCount)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R1

endmodule

// File: tb/rx_desc_dma_tb_top.sv
module rx_desc_dma_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0, pollDemand = 1'b0;
  logic [31:0] descBase = 32'h100;
  logic        frmValid = 1'b0, frmLast = 1'b0, frmErr = 1'b0;
  logic [7:0]  frmData = 8'h0;
  logic        frmReady, memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [15:0] missCount;

  int checks = 0, failures = 0, cyc = 0, wrCount = 0, ctlWrites = 0;
  int rd100 = 0, rd104 = 0, rd140 = 0, rd990 = 0;
  int unsigned mem [int unsigned];
  int unsigned expAddr[$], expData[$];

  always #4 clk = ~clk;

  rx_desc_dma dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .pollDemand(pollDemand),
    .descBase(descBase), .frmValid(frmValid), .frmData(frmData),
    .frmLast(frmLast), .frmErr(frmErr), .frmReady(frmReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .missCount(missCount)
  );

  task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory with one-cycle acknowledge
  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else begin
      memAck <= memReq && !memAck;
      if (memReq && !memAck) begin
        if (memWe) mem[memAddr] = memWdata;
        else memRdata <= mem.exists(memAddr) ? mem[memAddr] : 32'h0;
      end
    end
  end

  // reference comparison of every acknowledged access
  always @(negedge clk) begin
    if (rstN && memReq && memAck) begin
      if (memWe) begin
        wrCount++;
        if (memAddr == 32'h104 || memAddr == 32'h144) ctlWrites++;
        if (expAddr.size() == 0) check(1'b0, "R2/R3 unexpected write", memAddr, 0);
        else begin
          check(memAddr == expAddr[0], "R2/R3 write address", memAddr, expAddr[0]);
          check(memWdata == expData[0], "R2/R3 write data", memWdata, expData[0]);
          void'(expAddr.pop_front());
          void'(expData.pop_front());
        end
      end else begin
        if (memAddr == 32'h100) rd100++;
        if (memAddr == 32'h104) rd104++;
        if (memAddr == 32'h140) rd140++;
        if (memAddr >= 32'h990 && memAddr < 32'h9A0) rd990++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] byteVal(input int id, input int k);
    return 8'((id * 37 + k * 11 + 5) & 255);
  endfunction

  function automatic void expectFrame(input int id, input int unsigned desc, input int unsigned bufA,
                                      input int size, input int n, input bit err);
    int stored = (n < size) ? n : size;
    int unsigned sts;
    for (int w = 0; w * 4 < stored; w++) begin
      int unsigned d = 0;
      for (int j = 0; j < 4; j++)
        if (w * 4 + j < stored) d |= 32'(byteVal(id, w * 4 + j)) << (8 * j);
      expAddr.push_back(bufA + 4 * w);
      expData.push_back(d);
    end
    sts = (32'(n) << 16) | 32'h4000_0100 | ((err || n > size) ? 32'h8000 : 32'h0);
    expAddr.push_back(desc);
    expData.push_back(sts);
  endfunction

  task automatic sendFrame(input int id, input int n, input bit err, input bit pollLast);
    for (int k = 0; k < n; k++) begin
      frmValid = 1'b1;
      frmData = byteVal(id, k);
      frmLast = (k == n - 1);
      frmErr = err && (k == n - 1);
      pollDemand = pollLast && (k == n - 1);
      while (!frmReady) @(negedge clk);
      @(negedge clk);
      pollDemand = 1'b0;
    end
    frmValid = 1'b0; frmLast = 1'b0; frmErr = 1'b0;
  endtask

  initial begin
    int quiet;
    int missBefore, wrBefore;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(memReq == 1'b0, "R1 reset no request", memReq, 0);
    check(missCount == 16'd0, "R8 reset miss count", missCount, 0);

    mem[32'h100] = 32'h8000_0000; mem[32'h104] = 32'h0100_0040;
    mem[32'h108] = 32'h0000_1000; mem[32'h10C] = 32'h0000_0140;
    mem[32'h140] = 32'h8000_0000; mem[32'h144] = 32'h0200_0005;
    mem[32'h148] = 32'h0000_2000; mem[32'h14C] = 32'h0000_0990;
    rxEnable = 1'b1;
    repeat (20) @(negedge clk);
    check(rd104 == 1, "R1 owned descriptor fully read", rd104, 1);

    // R2 R3: normal frame, chained next pointer
    expectFrame(1, 32'h100, 32'h1000, 64, 10, 1'b0);
    sendFrame(1, 10, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(mem[32'h100] == 32'h400A_0100, "R3 status word", mem[32'h100], 32'h400A_0100);
    check(mem[32'h1008] == {16'h0, byteVal(1, 9), byteVal(1, 8)}, "R2 partial word lanes",
          mem[32'h1008], {16'h0, byteVal(1, 9), byteVal(1, 8)});
    check(rd140 == 1, "R6 chain pointer followed", rd140, 1);

    // R5: overflow of a 5-byte buffer, ring end wraps to base
    expectFrame(2, 32'h140, 32'h2000, 5, 9, 1'b0);
    sendFrame(2, 9, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(mem[32'h140] == 32'h4009_8100, "R5 overflow status", mem[32'h140], 32'h4009_8100);
    check(!mem.exists(32'h2008), "R5 no write beyond buffer", 0, 0);
    check(rd100 == 2, "R6 ring end returns to base", rd100, 2);
    check(rd990 == 0, "R6 word 3 ignored at ring end", rd990, 0);
    check(rd104 == 1, "R1 unowned descriptor not read further", rd104, 1);
    quiet = 0;
    for (int i = 0; i < 10; i++) begin
      if (memReq) quiet++;
      @(negedge clk);
    end
    check(quiet == 0, "R7 suspended no access", quiet, 0);

    // R8: frame while suspended
    wrBefore = wrCount;
    sendFrame(3, 6, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(missCount == 16'd1, "R8 missed frame counted", missCount, 1);
    check(wrCount == wrBefore, "R8 discarded frame not written", wrCount, wrBefore);

    // R7: host releases descriptor, poll demand
    mem[32'h100] = 32'h8000_0000;
    pollDemand = 1'b1;
    @(negedge clk);
    pollDemand = 1'b0;
    repeat (20) @(negedge clk);
    check(rd100 == 3, "R7 poll re-reads status", rd100, 3);

    // R4: error flag on last byte
    expectFrame(4, 32'h100, 32'h1000, 64, 4, 1'b1);
    sendFrame(4, 4, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    check(mem[32'h100] == 32'h4004_8100, "R4 error summary", mem[32'h100], 32'h4004_8100);

    // R10: poll on the last byte of a discarded frame
    mem[32'h140] = 32'h8000_0000;
    missBefore = int'(missCount);
    sendFrame(5, 5, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check(int'(missCount) == missBefore + 1, "R10 miss counted with poll", missCount, missBefore + 1);
    check(rd140 == 3, "R10 poll started fetch", rd140, 3);

    expectFrame(6, 32'h140, 32'h2000, 5, 3, 1'b0);
    sendFrame(6, 3, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(mem[32'h2000] == {8'h0, byteVal(6, 2), byteVal(6, 1), byteVal(6, 0)}, "R10 frame after poll",
          mem[32'h2000], {8'h0, byteVal(6, 2), byteVal(6, 1), byteVal(6, 0)});

    check(ctlWrites == 0, "R9 no control write", ctlWrites, 0);
    check(mem[32'h104] == 32'h0100_0040, "R9 control word kept", mem[32'h104], 32'h0100_0040);
    check(mem[32'h144] == 32'h0200_0005, "R9 control word kept", mem[32'h144], 32'h0200_0005);
    check(expAddr.size() == 0, "R3 all predicted writes seen", expAddr.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule